// File: doc/BRIEF.md
# Floating-Point Access Gate with Layered State Enables

This block keeps word 0 of three state-enable registers, one each for the machine, hypervisor and supervisor levels. From them it decides whether a floating-point instruction, or an access to the floating-point control/status register, is allowed at the current privilege level. The core sends a request together with its current privilege, its virtualization flag and a few static configuration flags. It gets back an allow or illegal-instruction verdict in the same cycle.

A level's master enable bit stops the levels below it from widening access. The floating-point enable bit is combined through the levels in cascade. That bit exists only when floating point runs on the integer registers. When hardware floating point is present, the bit is never stored, always reads as zero, and the gate lets requests through. The ordinary extension checks then govern them. A CSR write port and a read port give access to the registers. On a 32-bit build, the upper word of the machine and hypervisor registers is reached through a high-half select.

Top module: `stateen_fp_gate`

## Requirements
- R1: When a floating-point implementation exists (hardware or in-integer-register), a request at machine privilege (`priv_i` = 2'b11) is allowed. A request is also allowed when the state-enable feature is absent. Privilege encoding: 2'b00 user, 2'b01 supervisor, 2'b11 machine.
- R2: With neither hardware floating point nor the in-integer-register option, every request is reported illegal, machine mode included.
- R3: While the machine register's master enable (bit 63) is clear, the hypervisor and supervisor registers contribute zeros to the cascade.
- R4: With the virtualization flag set, the effective enable is machine AND hypervisor. If the hypervisor master bit (63) is clear, the supervisor register contributes zeros.
- R5: In user mode with the supervisor option present, the effective enable is also ANDed with the supervisor register. In supervisor mode, or without the option, the supervisor register is not used.
- R6: With hardware floating point absent and the in-integer option present, a request below machine mode is illegal exactly when the effective fcsr-enable bit (bit 1) is clear. With hardware floating point present, requests are allowed. With no request, both outputs are low.
- R7: A write stores only bit 63 (master), bit 62 (environment-config enable) and bit 1 (fcsr enable). Bit 1 is stored only when hardware floating point is absent. All other bits read as zero.
- R8: A request flagged as coming from a debugger bypasses the state-enable check.
- R9: All registers are zero after synchronous reset. A write takes effect at the next rising edge. The verdict follows inputs and register contents combinationally.
- R10: Write select encoding: 0 machine, 1 hypervisor, 2 supervisor, 3 none. When XLEN is 64, high-half writes are ignored and high-half reads return zero. The supervisor register has no high half. Select 3 writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Virtualized execution flag |
| cfg_stateen_i | input | 1 | State-enable feature implemented |
| cfg_fpu_i | input | 1 | Hardware floating point present |
| cfg_smode_i | input | 1 | Supervisor mode implemented |
| cfg_finx_i | input | 1 | Floating point on integer registers present |
| dbg_i | input | 1 | Request comes from a debugger |
| fp_req_i | input | 1 | Floating-point instruction or fcsr access requested |
| wr_en_i | input | 1 | CSR write strobe |
| wr_sel_i | input | 2 | Register selected for write |
| wr_hi_i | input | 1 | Write targets the upper half |
| wr_data_i | input | XLEN | Write data |
| rd_sel_i | input | 2 | Register selected for read |
| rd_hi_i | input | 1 | Read targets the upper half |
| rd_data_o | output | XLEN | Read data |
| fp_allow_o | output | 1 | Request permitted |
| fp_illegal_o | output | 1 | Request raises illegal instruction |

## Verification
The bench targets four weak points of the cascade:
- A cleared machine master bit must hide a still-set supervisor fcsr bit. A design that forgot this would allow user-mode access.
- A cleared hypervisor master bit under virtualization must hide the supervisor value, in the same way.
- The supervisor register must be ignored in supervisor mode and when supervisor mode is absent. A design that got this wrong would trap legal requests.
- The fcsr bit must read as zero when hardware floating point exists.

It also checks three bypass and port cases. A debugger request must pass, and machine mode must pass. A request with no floating point at all must be illegal even in machine mode. High-half writes on a 64-bit build must leave the stored value untouched.

// File: rtl/stateen_gate_pkg.sv
package stateen_gate_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        LVL_MACH = 2'd0,
        LVL_HYP  = 2'd1,
        LVL_SUP  = 2'd2,
        LVL_NONE = 2'd3
    } lvl_e;

    localparam int NUM_LVL    = 3;
    localparam int BIT_MASTER = 63;
    localparam int BIT_ENVCFG = 62;
    localparam int BIT_FCSR   = 1;

    // Only the implemented bits of a level are held.
    typedef struct packed {
        logic master;
        logic envcfg;
        logic fcsr;
    } en_bits_t;

    function automatic en_bits_t merge_write(en_bits_t cur, logic [63:0] img,
                                             logic [63:0] touch, logic fcsr_ok);
        en_bits_t nxt;
        nxt = cur;
        if (touch[BIT_MASTER]) nxt.master = img[BIT_MASTER];
        if (touch[BIT_ENVCFG]) nxt.envcfg = img[BIT_ENVCFG];
        if (touch[BIT_FCSR])   nxt.fcsr   = img[BIT_FCSR] & fcsr_ok;
        return nxt;
    endfunction

    function automatic logic [63:0] to_image(en_bits_t b);
        logic [63:0] img;
        img = '0;
        img[BIT_MASTER] = b.master;
        img[BIT_ENVCFG] = b.envcfg;
        img[BIT_FCSR]   = b.fcsr;
        return img;
    endfunction

    function automatic en_bits_t en_and(en_bits_t a, en_bits_t b);
        en_bits_t r;
        r.master = a.master & b.master;
        r.envcfg = a.envcfg & b.envcfg;
        r.fcsr   = a.fcsr   & b.fcsr;
        return r;
    endfunction

endpackage

// File: rtl/stateen_word_map.sv
module stateen_word_map #(
    parameter int XLEN = 64
) (
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wr_data,
    input  logic            rd_hi,
    input  logic [63:0]     rd_img,
    output logic            wr_ok,
    output logic [63:0]     wr_img,
    output logic [63:0]     wr_touch,
    output logic [XLEN-1:0] rd_word
);
    localparam int HALF = 32;

    generate
        if (XLEN == 64) begin : g_wide
            assign wr_ok    = !wr_hi;
            assign wr_img   = wr_data;
            assign wr_touch = '1;
            assign rd_word  = rd_hi ? '0 : rd_img;
        end else if (XLEN == 32) begin : g_narrow
            assign wr_ok    = 1'b1;
            assign wr_img   = wr_hi ? {wr_data, {HALF{1'b0}}} : {{HALF{1'b0}}, wr_data};
            assign wr_touch = wr_hi ? {{HALF{1'b1}}, {HALF{1'b0}}}
                                    : {{HALF{1'b0}}, {HALF{1'b1}}};
            assign rd_word  = rd_hi ? rd_img[63:32] : rd_img[31:0];
        end else begin : g_bad
            initial $error("stateen_word_map: XLEN must be 32 or 64");
            assign wr_ok    = 1'b0;
            assign wr_img   = '0;
            assign wr_touch = '0;
            assign rd_word  = '0;
        end
    endgenerate
endmodule

// File: rtl/stateen_level_reg.sv
module stateen_level_reg
    import stateen_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [63:0] wr_img,
    input  logic [63:0] wr_touch,
    input  logic        fcsr_ok,
    output en_bits_t    q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= merge_write(q, wr_img, wr_touch, fcsr_ok);
    end

    AST_FCSR_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !fcsr_ok |=> !q.fcsr); // R7
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q)); // R9
endmodule

// File: rtl/stateen_cascade.sv
module stateen_cascade
    import stateen_gate_pkg::*;
(
    input  en_bits_t   mach,
    input  en_bits_t   hyp,
    input  en_bits_t   sup,
    input  logic       virt,
    input  logic [1:0] priv,
    input  logic       has_smode,
    output en_bits_t   eff
);
    en_bits_t hyp_v;
    en_bits_t sup_v;

    always_comb begin
        // Machine master gates both lower levels.
        hyp_v = mach.master ? hyp : '0;
        sup_v = mach.master ? sup : '0;
        eff   = mach;
        if (virt) begin
            eff = en_and(eff, hyp_v);
            if (!hyp_v.master) sup_v = '0;
        end
        if (priv == PRIV_U && has_smode) eff = en_and(eff, sup_v);
    end
endmodule

// File: rtl/fp_gate_decide.sv
module fp_gate_decide
    import stateen_gate_pkg::*;
(
    input  logic       req,
    input  logic [1:0] priv,
    input  logic       cfg_stateen,
    input  logic       cfg_fpu,
    input  logic       cfg_finx,
    input  logic       dbg,
    input  logic       eff_fcsr,
    output logic       allow,
    output logic       illegal
);
    logic deny;

    always_comb begin
        deny = 1'b0;
        if (!cfg_fpu) begin
            if (!cfg_finx)
                deny = 1'b1;
            else if (cfg_stateen && priv != PRIV_M && !dbg && !eff_fcsr)
                deny = 1'b1;
        end
        illegal = req & deny;
        allow   = req & !deny;
    end
endmodule

// File: rtl/stateen_fp_gate.sv
module stateen_fp_gate
    import stateen_gate_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            cfg_stateen_i,
    input  logic            cfg_fpu_i,
    input  logic            cfg_smode_i,
    input  logic            cfg_finx_i,
    input  logic            dbg_i,
    input  logic            fp_req_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic            wr_hi_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [1:0]      rd_sel_i,
    input  logic            rd_hi_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            fp_allow_o,
    output logic            fp_illegal_o
);
    logic        wr_ok;
    logic [63:0] wr_img;
    logic [63:0] wr_touch;
    logic [63:0] rd_img;
    en_bits_t    lvl_q [NUM_LVL];
    en_bits_t    eff;

    stateen_word_map #(.XLEN(XLEN)) u_map (
        .wr_hi    (wr_hi_i),
        .wr_data  (wr_data_i),
        .rd_hi    (rd_hi_i),
        .rd_img   (rd_img),
        .wr_ok    (wr_ok),
        .wr_img   (wr_img),
        .wr_touch (wr_touch),
        .rd_word  (rd_data_o)
    );

    for (genvar L = 0; L < NUM_LVL; L++) begin : g_lvl
        logic we;
        // The supervisor register has no upper half.
        assign we = wr_en_i && wr_ok && (wr_sel_i == 2'(L))
                    && !((L == int'(LVL_SUP)) && wr_hi_i);
        stateen_level_reg u_reg (
            .clk      (clk),
            .rst      (rst),
            .we       (we),
            .wr_img   (wr_img),
            .wr_touch (wr_touch),
            .fcsr_ok  (!cfg_fpu_i),
            .q        (lvl_q[L])
        );
    end

    always_comb begin
        case (rd_sel_i)
            LVL_MACH: rd_img = to_image(lvl_q[0]);
            LVL_HYP:  rd_img = to_image(lvl_q[1]);
            LVL_SUP:  rd_img = rd_hi_i ? '0 : to_image(lvl_q[2]);
            default:  rd_img = '0;
        endcase
    end

    stateen_cascade u_cascade (
        .mach      (lvl_q[0]),
        .hyp       (lvl_q[1]),
        .sup       (lvl_q[2]),
        .virt      (virt_i),
        .priv      (priv_i),
        .has_smode (cfg_smode_i),
        .eff       (eff)
    );

    fp_gate_decide u_decide (
        .req         (fp_req_i),
        .priv        (priv_i),
        .cfg_stateen (cfg_stateen_i),
        .cfg_fpu     (cfg_fpu_i),
        .cfg_finx    (cfg_finx_i),
        .dbg         (dbg_i),
        .eff_fcsr    (eff.fcsr),
        .allow       (fp_allow_o),
        .illegal     (fp_illegal_o)
    );

    AST_MACHINE_ALLOWED: assert property (@(posedge clk) disable iff (rst)
        fp_req_i && priv_i == PRIV_M && (cfg_fpu_i || cfg_finx_i) |-> fp_allow_o); // R1
    AST_NO_FP_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        fp_req_i && !cfg_fpu_i && !cfg_finx_i |-> fp_illegal_o); // R2
    AST_MASTER_HIDES_LOWER: assert property (@(posedge clk) disable iff (rst)
        !lvl_q[0].master && (virt_i || (priv_i == PRIV_U && cfg_smode_i)) |-> !eff.fcsr); // R3
    AST_EFF_BOUNDED_BY_MACH: assert property (@(posedge clk) disable iff (rst)
        eff.fcsr |-> lvl_q[0].fcsr); // R4
    AST_FPU_PRESENT_ALLOWS: assert property (@(posedge clk) disable iff (rst)
        fp_req_i && cfg_fpu_i |-> fp_allow_o && !fp_illegal_o); // R6
    AST_DEBUG_BYPASS: assert property (@(posedge clk) disable iff (rst)
        fp_req_i && dbg_i && cfg_finx_i |-> fp_allow_o); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fp_req_i |-> !fp_allow_o && !fp_illegal_o); // R6
endmodule

// File: tb/test_stateen_fp_gate.sv
module test_stateen_fp_gate;
    localparam int XLEN = 64;
    localparam logic [63:0] KEEP = 64'hC000_0000_0000_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic [1:0] priv = 2'b11;
    logic virt = 0, cfg_stateen = 1, cfg_fpu = 0, cfg_smode = 1, cfg_finx = 1;
    logic dbg = 0, req = 1, wr_en = 0, wr_hi = 0, rd_hi = 0;
    logic [1:0] wr_sel = 2'd3, rd_sel = 2'd0;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] rd_data;
    logic fp_allow, fp_illegal;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R9";
    logic [63:0] mdl [3];

    stateen_fp_gate #(.XLEN(XLEN)) i_stateen_fp_gate (
        .clk(clk), .rst(rst), .priv_i(priv), .virt_i(virt),
        .cfg_stateen_i(cfg_stateen), .cfg_fpu_i(cfg_fpu), .cfg_smode_i(cfg_smode),
        .cfg_finx_i(cfg_finx), .dbg_i(dbg), .fp_req_i(req),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_hi_i(rd_hi), .rd_data_o(rd_data),
        .fp_allow_o(fp_allow), .fp_illegal_o(fp_illegal)
    );

    // Reference model: full 64-bit images, updated on the clock.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) mdl[i] <= '0;
        end else if (wr_en && !wr_hi && wr_sel != 2'd3) begin
            mdl[wr_sel] <= wr_data & (KEEP | (cfg_fpu ? 64'h0 : 64'h2));
        end
    end

    function automatic logic exp_illegal();
        logic [63:0] m, h, s, e;
        if (!req) return 1'b0;
        if (!cfg_fpu && !cfg_finx) return 1'b1;
        if (cfg_fpu) return 1'b0;
        if (!cfg_stateen || priv == 2'b11) return 1'b0;
        if (dbg) return 1'b0;
        m = mdl[0]; h = mdl[1]; s = mdl[2];
        if (!m[63]) begin h = '0; s = '0; end
        e = m;
        if (virt) begin
            e = e & h;
            if (!h[63]) s = '0;
        end
        if (priv == 2'b00 && cfg_smode) e = e & s;
        return !e[1];
    endfunction

    function automatic logic [63:0] exp_rd();
        if (rd_hi || rd_sel == 2'd3) return '0;
        return mdl[rd_sel];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " illegal vs model"}, 64'(fp_illegal), 64'(exp_illegal()));
            check({cur_req, " allow vs model"}, 64'(fp_allow), 64'(req & !exp_illegal()));
            check({cur_req, " read vs model"}, rd_data, exp_rd());
        end
    end

    task automatic wr(input logic [1:0] sel, input logic hi, input logic [63:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_hi = hi; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; wr_sel = 2'd3; wr_hi = 0;
    endtask

    task automatic expect_ill(string tag, logic exp);
        @(negedge clk);
        check(tag, 64'(fp_illegal), 64'(exp));
        check(tag, 64'(fp_allow), 64'(req & !exp));
        #1;
    endtask

    task automatic expect_rd(string tag, logic [1:0] sel, logic hi, logic [63:0] exp);
        rd_sel = sel; rd_hi = hi;
        @(negedge clk);
        check(tag, rd_data, exp);
        #1;
        rd_hi = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic random_phase(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            case ($urandom % 3)
                0: priv = 2'b00;
                1: priv = 2'b01;
                default: priv = 2'b11;
            endcase
            virt = 1'($urandom); cfg_smode = 1'($urandom);
            cfg_stateen = ($urandom % 5) != 0; cfg_finx = ($urandom % 6) != 0;
            dbg = ($urandom % 7) == 0; req = ($urandom % 4) != 0;
            wr_en = ($urandom % 3) == 0; wr_sel = 2'($urandom);
            wr_hi = ($urandom % 8) == 0;
            wr_data = {$urandom, $urandom};
            rd_sel = 2'($urandom); rd_hi = ($urandom % 6) == 0;
        end
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9: reset state
        cur_req = "R9";
        expect_rd("R9 reset machine reads zero", 2'd0, 0, 64'h0);
        expect_rd("R9 reset supervisor reads zero", 2'd2, 0, 64'h0);
        priv = 2'b00;
        expect_ill("R9 user after reset illegal", 1);
        // R1
        cur_req = "R1";
        priv = 2'b11;
        expect_ill("R1 machine allowed", 0);
        priv = 2'b00; cfg_stateen = 0;
        expect_ill("R1 feature absent allowed", 0);
        cfg_stateen = 1;
        // R7 masking + R6
        cur_req = "R7";
        wr(2'd0, 0, '1);
        expect_rd("R7 machine write mask", 2'd0, 0, 64'hC000_0000_0000_0002);
        cur_req = "R6";
        priv = 2'b01;
        expect_ill("R6 supervisor with machine fcsr set allowed", 0);
        // R5
        cur_req = "R5";
        priv = 2'b00;
        expect_ill("R5 user with supervisor fcsr clear illegal", 1);
        cfg_smode = 0;
        expect_ill("R5 user without S mode ignores supervisor reg", 0);
        cfg_smode = 1;
        wr(2'd2, 0, 64'h2);
        expect_ill("R5 user with supervisor fcsr set allowed", 0);
        // R3
        cur_req = "R3";
        wr(2'd0, 0, 64'h2);
        expect_ill("R3 machine master clear hides supervisor", 1);
        priv = 2'b01;
        expect_ill("R3 supervisor uses machine value only", 0);
        // R4
        cur_req = "R4";
        wr(2'd0, 0, '1);
        virt = 1;
        expect_ill("R4 virt with hypervisor clear illegal", 1);
        wr(2'd1, 0, 64'h2);
        expect_ill("R4 virt supervisor with hypervisor fcsr allowed", 0);
        priv = 2'b00;
        expect_ill("R4 hypervisor master clear hides supervisor", 1);
        wr(2'd1, 0, 64'h8000_0000_0000_0002);
        expect_ill("R4 hypervisor master set passes supervisor", 0);
        // R8
        cur_req = "R8";
        wr(2'd2, 0, 64'h0);
        expect_ill("R8 supervisor cleared now illegal", 1);
        dbg = 1;
        expect_ill("R8 debugger bypass", 0);
        dbg = 0;
        // R2
        cur_req = "R2";
        cfg_finx = 0; priv = 2'b11;
        expect_ill("R2 no floating point illegal in machine", 1);
        cfg_finx = 1;
        // R10
        cur_req = "R10";
        wr(2'd0, 1, 64'h0);
        expect_rd("R10 high write ignored", 2'd0, 0, 64'hC000_0000_0000_0002);
        expect_rd("R10 high read zero", 2'd0, 1, 64'h0);
        wr(2'd3, 0, '1);
        expect_rd("R10 select none reads zero", 2'd3, 0, 64'h0);
        expect_rd("R10 select none writes nothing", 2'd2, 0, 64'h0);
        // R7 other bits
        cur_req = "R7";
        wr(2'd2, 0, 64'h3FFF_FFFF_FFFF_FFFD);
        expect_rd("R7 unimplemented bits read zero", 2'd2, 0, 64'h0);
        // R6 no request
        cur_req = "R6";
        req = 0;
        expect_ill("R6 no request quiet", 0);
        req = 1;
        cur_req = "R9";
        random_phase(3000);
        // Hardware floating point present.
        @(posedge clk); #1;
        rst = 1; cfg_fpu = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        cfg_stateen = 1; cfg_finx = 1; req = 1; dbg = 0; virt = 0; priv = 2'b00;
        cur_req = "R7";
        wr(2'd0, 0, '1);
        expect_rd("R7 fcsr bit not kept with FPU", 2'd0, 0, 64'hC000_0000_0000_0000);
        cur_req = "R6";
        expect_ill("R6 FPU present allowed", 0);
        random_phase(3000);
        done = 1;
        summary();
        $finish;
    end
endmodule